// File: doc/BRIEF.md
# Bidirectional Digital Ramp Generator

This block sweeps a 32-bit unsigned accumulator between a programmable lower bound and upper bound. A direction input chooses the slope. While it is high, the accumulator climbs by the rising step once every rising interval. While it is low, the accumulator descends by the falling step once every falling interval. The result saturates at the bound it is heading for. A registered flag reports that the accumulator is parked at the bound of its current slope. Optional no-dwell controls turn a parked bound into a jump to the opposite bound, which gives sawtooth sweeps.

The accumulator is presented on a 32-bit parameter output. The destination code selects how it is aligned for the consuming parameter:
- full 32 bits for frequency;
- top 16 bits for phase;
- top 14 bits for amplitude.

In each case the selected bits are right-justified and the upper output bits are zero. A clear input holds the accumulator at zero. An autoclear input zeroes it once when an update strobe arrives. An enable input freezes the whole block, as a gated clock would.

The accumulator is steered by a small state machine with five states:
- CLEARED is entered from any state while clear is high.
- RISING is entered on a rising step, on autoclear with direction high, or on an idle cycle with direction high from CLEARED, FALLING or AT_LOW.
- AT_HIGH is entered when a rising step saturates at the upper bound.
- FALLING is entered on a falling step, on autoclear with direction low, or on an idle cycle with direction low from CLEARED, RISING or AT_HIGH.
- AT_LOW is entered when a falling step saturates at the lower bound.
- The no-dwell jump from AT_HIGH leads to RISING, and the jump from AT_LOW leads to FALLING.

Top module: `dramp_gen`

## Requirements
- R1: After reset, the accumulator is 0, the limit flag `at_limit` is 0 and `param_out` is 0.
- R2: `dest`=00 gives `param_out`=acc. `dest`=01 gives `param_out[15:0]`=acc[31:16] with the upper bits 0. `dest`=1x gives `param_out[13:0]`=acc[31:18] with the upper bits 0.
- R3: While `en` is 0, the accumulator, the interval timer and the flag hold their values. All other controls, including `clr` and `dir` changes, have no effect.
- R4: While `clr` is 1 (and `en` is 1), the accumulator becomes 0 at each edge, taking priority over every other control, and the flag is 0.
- R5: When `autoclr` and `io_upd` are both 1 at an edge, the accumulator becomes 0 at that edge only, and no step is taken at that edge.
- R6: With `dir`=1, the accumulator adds `step_up` once every `rate_up` cycles (0 acts as 1). A sum that reaches or passes `lim_hi`, or overflows 32 bits, yields `lim_hi`.
- R7: With `dir`=0, the accumulator subtracts `step_dn` once every `rate_dn` cycles (0 acts as 1). A difference that reaches or falls below `lim_lo`, or underflows, yields `lim_lo`.
- R8: `at_limit` is 1 from the edge at which a rising step saturates at `lim_hi` (or a falling step at `lim_lo`) until a step leaves that bound, the direction changes, or a clear occurs.
- R9: With `nodwell_hi`=1, the first rising step taken while parked at the upper bound loads `lim_lo`, and the flag drops.
- R10: With `nodwell_lo`=1, the first falling step taken while parked at the lower bound loads `lim_hi`, and the flag drops.
- R11: The interval countdown restarts at the full interval, with no step at that edge, when `dir` differs from its value at the previous enabled edge, or when `io_upd` is 1 with `load_rate_upd`=1. `io_upd` alone does not disturb the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; 0 freezes all state |
| dest | input | 2 | Destination alignment code |
| lim_hi | input | 32 | Upper sweep bound |
| lim_lo | input | 32 | Lower sweep bound |
| step_up | input | 32 | Rising step size |
| step_dn | input | 32 | Falling step size |
| rate_up | input | 16 | Rising step interval in cycles |
| rate_dn | input | 16 | Falling step interval in cycles |
| dir | input | 1 | Slope select, 1 = rising |
| clr | input | 1 | Hold accumulator at zero |
| autoclr | input | 1 | Zero accumulator on the next update strobe |
| nodwell_hi | input | 1 | Jump to lower bound after parking at upper bound |
| nodwell_lo | input | 1 | Jump to upper bound after parking at lower bound |
| load_rate_upd | input | 1 | Restart interval countdown on update strobe |
| io_upd | input | 1 | Update strobe |
| param_out | output | 32 | Aligned parameter word |
| at_limit | output | 1 | Parked at the bound of the current slope |

## Verification
The properties assume that `lim_lo` does not exceed `lim_hi`. They also assume that the bounds do not move in the cycle that a saturation flag or a monotonic step is judged against. Without that, a step toward a moved bound could legitimately reverse direction. The stimulus changes the bounds only while `clr` holds the accumulator at zero, and always keeps the lower bound below the upper one. All inputs are driven on the falling clock edge, so every property sees settled values.

// File: rtl/dramp_pkg.sv
package dramp_pkg;
    typedef enum logic [2:0] {
        ST_CLEARED = 3'd0,
        ST_RISING  = 3'd1,
        ST_AT_HIGH = 3'd2,
        ST_FALLING = 3'd3,
        ST_AT_LOW  = 3'd4
    } ramp_state_t;
endpackage

// File: rtl/dramp_timer.sv
module dramp_timer #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir,
    input  logic [RATE_W-1:0] rate_up,
    input  logic [RATE_W-1:0] rate_dn,
    input  logic              io_upd,
    input  logic              load_rate_upd,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] reload_val;
    logic [RATE_W-1:0] rate_sel;
    logic              dir_q;
    logic              restart;

    always_comb begin
        rate_sel   = dir ? rate_up : rate_dn;
        reload_val = (rate_sel == '0) ? '0 : rate_sel - 1'b1;
        restart    = (dir != dir_q) || (io_upd && load_rate_upd);
        tick       = en && (cnt_q == '0) && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (en) begin
            dir_q <= dir;
            if (restart || cnt_q == '0) begin
                cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dramp_core.sv
module dramp_core
    import dramp_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             dir,
    input  logic             clr,
    input  logic             autoclr,
    input  logic             io_upd,
    input  logic             nodwell_hi,
    input  logic             nodwell_lo,
    input  logic [ACC_W-1:0] lim_hi,
    input  logic [ACC_W-1:0] lim_lo,
    input  logic [ACC_W-1:0] step_up,
    input  logic [ACC_W-1:0] step_dn,
    output logic [ACC_W-1:0] acc,
    output ramp_state_t      state,
    output logic             at_limit
);
    ramp_state_t      st_q, st_d;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic [ACC_W:0]   up_sum;
    logic [ACC_W-1:0] dn_dif;
    logic             dn_under;

    always_comb begin
        up_sum   = {1'b0, acc_q} + {1'b0, step_up};
        dn_under = step_dn > acc_q;
        dn_dif   = acc_q - step_dn;
        st_d     = st_q;
        acc_d    = acc_q;
        if (clr) begin
            acc_d = '0;
            st_d  = ST_CLEARED;
        end else if (autoclr && io_upd) begin
            acc_d = '0;
            st_d  = dir ? ST_RISING : ST_FALLING;
        end else if (tick) begin
            if (dir) begin
                if (st_q == ST_AT_HIGH && nodwell_hi) begin
                    acc_d = lim_lo;
                    st_d  = ST_RISING;
                end else if (up_sum[ACC_W] || up_sum[ACC_W-1:0] >= lim_hi) begin
                    acc_d = lim_hi;
                    st_d  = ST_AT_HIGH;
                end else begin
                    acc_d = up_sum[ACC_W-1:0];
                    st_d  = ST_RISING;
                end
            end else begin
                if (st_q == ST_AT_LOW && nodwell_lo) begin
                    acc_d = lim_hi;
                    st_d  = ST_FALLING;
                end else if (dn_under || dn_dif <= lim_lo) begin
                    acc_d = lim_lo;
                    st_d  = ST_AT_LOW;
                end else begin
                    acc_d = dn_dif;
                    st_d  = ST_FALLING;
                end
            end
        end else begin
            unique case (st_q)
                ST_CLEARED:             st_d = dir ? ST_RISING : ST_FALLING;
                ST_RISING, ST_AT_HIGH:  st_d = dir ? st_q : ST_FALLING;
                ST_FALLING, ST_AT_LOW:  st_d = dir ? ST_RISING : st_q;
                default:                st_d = ST_CLEARED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CLEARED;
            acc_q <= '0;
        end else if (en) begin
            st_q  <= st_d;
            acc_q <= acc_d;
        end
    end

    always_comb begin
        acc      = acc_q;
        state    = st_q;
        at_limit = (st_q == ST_AT_HIGH) || (st_q == ST_AT_LOW);
    end
endmodule

// File: rtl/dramp_map.sv
module dramp_map #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 16,
    parameter int AMP_W   = 14
) (
    input  logic [1:0]       dest,
    input  logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] param_out
);
    localparam int PH_SHIFT = ACC_W - PHASE_W;
    localparam int AM_SHIFT = ACC_W - AMP_W;

    always_comb begin
        unique casez (dest)
            2'b00:   param_out = acc;
            2'b01:   param_out = acc >> PH_SHIFT;
            2'b1?:   param_out = acc >> AM_SHIFT;
            default: param_out = acc;
        endcase
    end
endmodule

// File: rtl/dramp_gen.sv
module dramp_gen
    import dramp_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int RATE_W  = 16,
    parameter int PHASE_W = 16,
    parameter int AMP_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        dest,
    input  logic [ACC_W-1:0]  lim_hi,
    input  logic [ACC_W-1:0]  lim_lo,
    input  logic [ACC_W-1:0]  step_up,
    input  logic [ACC_W-1:0]  step_dn,
    input  logic [RATE_W-1:0] rate_up,
    input  logic [RATE_W-1:0] rate_dn,
    input  logic              dir,
    input  logic              clr,
    input  logic              autoclr,
    input  logic              nodwell_hi,
    input  logic              nodwell_lo,
    input  logic              load_rate_upd,
    input  logic              io_upd,
    output logic [ACC_W-1:0]  param_out,
    output logic              at_limit
);
    logic             tick;
    logic [ACC_W-1:0] acc;
    ramp_state_t      state;

    dramp_timer #(.RATE_W(RATE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .dir(dir),
        .rate_up(rate_up), .rate_dn(rate_dn),
        .io_upd(io_upd), .load_rate_upd(load_rate_upd), .tick(tick)
    );

    dramp_core #(.ACC_W(ACC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .dir(dir),
        .clr(clr), .autoclr(autoclr), .io_upd(io_upd),
        .nodwell_hi(nodwell_hi), .nodwell_lo(nodwell_lo),
        .lim_hi(lim_hi), .lim_lo(lim_lo),
        .step_up(step_up), .step_dn(step_dn),
        .acc(acc), .state(state), .at_limit(at_limit)
    );

    dramp_map #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_map (
        .dest(dest), .acc(acc), .param_out(param_out)
    );
endmodule

// File: rtl/dramp_chk.sv
module dramp_chk
    import dramp_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       dest,
    input logic [ACC_W-1:0] lim_hi,
    input logic [ACC_W-1:0] lim_lo,
    input logic             dir,
    input logic             clr,
    input logic             autoclr,
    input logic             io_upd,
    input logic             nodwell_hi,
    input logic             tick,
    input logic [ACC_W-1:0] acc,
    input ramp_state_t      state,
    input logic [ACC_W-1:0] param_out,
    input logic             at_limit
);
    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (acc == '0 && !at_limit));

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(acc) && $stable(at_limit)));

    // R2
    phase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dest == 2'b01) |-> (param_out[ACC_W-1:16] == '0 && param_out[15:0] == acc[ACC_W-1:ACC_W-16]));

    // R2
    amp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dest[1] |-> (param_out[ACC_W-1:14] == '0 && param_out[13:0] == acc[ACC_W-1:ACC_W-14]));

    // R6
    rise_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir && !clr && !(autoclr && io_upd) && !nodwell_hi && acc <= lim_hi) |=> (acc >= $past(acc)));

    // R8
    flag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(at_limit) && $stable(lim_hi) && $stable(lim_lo)) |-> (acc == lim_hi || acc == lim_lo));

    // R9
    nodwell_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && dir && state == ST_AT_HIGH && nodwell_hi && !clr && !(autoclr && io_upd))
        |=> (acc == $past(lim_lo) && !at_limit));
endmodule

bind dramp_gen dramp_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .dest(dest),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .dir(dir), .clr(clr),
    .autoclr(autoclr), .io_upd(io_upd), .nodwell_hi(nodwell_hi),
    .tick(tick), .acc(acc), .state(state),
    .param_out(param_out), .at_limit(at_limit)
);

// File: tb/sim_dramp_gen.sv
module sim_dramp_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  dest = 2'b00;
    logic [31:0] lim_hi = '0, lim_lo = '0, step_up = '0, step_dn = '0;
    logic [15:0] rate_up = '0, rate_dn = '0;
    logic        dir = 1'b0, clr = 1'b0, autoclr = 1'b0;
    logic        nodwell_hi = 1'b0, nodwell_lo = 1'b0;
    logic        load_rate_upd = 1'b0, io_upd = 1'b0;
    logic [31:0] param_out;
    logic        at_limit;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [31:0] q_p[$];
    logic        q_f[$];
    string       q_r[$];

    always #(CLK_P/2) clk = ~clk;

    dramp_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .dest(dest),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .step_up(step_up), .step_dn(step_dn),
        .rate_up(rate_up), .rate_dn(rate_dn), .dir(dir), .clr(clr),
        .autoclr(autoclr), .nodwell_hi(nodwell_hi), .nodwell_lo(nodwell_lo),
        .load_rate_upd(load_rate_upd), .io_upd(io_upd),
        .param_out(param_out), .at_limit(at_limit)
    );

    // Reference model of the requirements; states: 0 cleared, 1 rising,
    // 2 parked high, 3 falling, 4 parked low.
    logic [31:0] m_acc = '0;
    logic [15:0] m_cnt = '0;
    logic        m_dq = 1'b0;
    int          m_st = 0;

    function automatic logic [31:0] align(input logic [1:0] d, input logic [31:0] a);
        if (d == 2'b00) return a;
        if (d == 2'b01) return {16'h0, a[31:16]};
        return {18'h0, a[31:18]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_cnt = '0; m_dq = 1'b0; m_st = 0;
        end else if (en) begin
            logic        restart, step;
            logic [15:0] r;
            logic [32:0] s;
            restart = (dir != m_dq) || (io_upd && load_rate_upd);
            step    = (m_cnt == 0) && !restart;
            r       = dir ? rate_up : rate_dn;
            if (restart || m_cnt == 0) m_cnt = (r == 0) ? 16'd0 : r - 16'd1;
            else m_cnt = m_cnt - 16'd1;
            m_dq = dir;
            if (clr) begin
                m_acc = '0; m_st = 0;
            end else if (autoclr && io_upd) begin
                m_acc = '0; m_st = dir ? 1 : 3;
            end else if (step) begin
                if (dir) begin
                    s = {1'b0, m_acc} + {1'b0, step_up};
                    if (m_st == 2 && nodwell_hi) begin m_acc = lim_lo; m_st = 1; end
                    else if (s[32] || s[31:0] >= lim_hi) begin m_acc = lim_hi; m_st = 2; end
                    else begin m_acc = s[31:0]; m_st = 1; end
                end else begin
                    if (m_st == 4 && nodwell_lo) begin m_acc = lim_hi; m_st = 3; end
                    else if (step_dn > m_acc || m_acc - step_dn <= lim_lo) begin m_acc = lim_lo; m_st = 4; end
                    else begin m_acc = m_acc - step_dn; m_st = 3; end
                end
            end else if (dir && m_st != 1 && m_st != 2) begin
                m_st = 1;
            end else if (!dir && m_st != 3 && m_st != 4) begin
                m_st = 3;
            end
        end
        q_p.push_back(align(dest, m_acc));
        q_f.push_back(m_st == 2 || m_st == 4);
        q_r.push_back(cur_req);
    end

    always @(posedge clk) begin
        #(CLK_P/4);
        if (q_p.size() > 0 && !done) begin
            logic [31:0] ep;
            logic        ef;
            string       rq;
            ep = q_p.pop_front();
            ef = q_f.pop_front();
            rq = q_r.pop_front();
            n_vec++;
            if (param_out !== ep || at_limit !== ef) begin
                n_bad++;
                $display("FAIL %s: param_out=%h at_limit=%b expected param_out=%h at_limit=%b",
                         rq, param_out, at_limit, ep, ef);
            end
        end
    end

    task automatic run(input int n, input string r);
        cur_req = r;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        run(3, "R1");
        rst_n = 1'b1;
        run(3, "R1");
        // R6 rising ramp to upper bound, R8 flag there
        en = 1'b1; clr = 1'b1; lim_lo = 32'd100; lim_hi = 32'd1000;
        step_up = 32'd37; step_dn = 32'd53; rate_up = 16'd3; rate_dn = 16'd5;
        run(2, "R4");
        clr = 1'b0; dir = 1'b1;
        run(100, "R6");
        run(5, "R8");
        // R7 falling ramp to lower bound, R8 flag there
        dir = 1'b0;
        run(110, "R7");
        run(5, "R8");
        // R9 no-dwell at the upper bound
        nodwell_hi = 1'b1; dir = 1'b1; step_up = 32'd300; rate_up = 16'd2;
        run(40, "R9");
        nodwell_hi = 1'b0;
        // R10 no-dwell at the lower bound
        nodwell_lo = 1'b1; dir = 1'b0; step_dn = 32'd250; rate_dn = 16'd1;
        run(30, "R10");
        nodwell_lo = 1'b0;
        // R2 alignment with large values and overflow saturation
        clr = 1'b1; run(1, "R4");
        lim_lo = 32'h0001_0000; lim_hi = 32'hFFFF_FFF0;
        step_up = 32'h1234_5679; rate_up = 16'd0; clr = 1'b0; dir = 1'b1;
        run(6, "R2");
        dest = 2'b01; run(6, "R2");
        dest = 2'b10; run(4, "R2");
        dest = 2'b11; dir = 1'b0; step_dn = 32'h2345_6781; rate_dn = 16'd0;
        run(6, "R2");
        dest = 2'b00;
        // R11 restart on update with load enabled, and not without it
        clr = 1'b1; run(1, "R4");
        lim_lo = 32'd0; lim_hi = 32'd5000; step_up = 32'd7; rate_up = 16'd6;
        clr = 1'b0; dir = 1'b1;
        run(8, "R11");
        for (int i = 0; i < 4; i++) begin
            io_upd = 1'b1; run(1, "R11");
            io_upd = 1'b0; run(3, "R11");
        end
        load_rate_upd = 1'b1;
        for (int i = 0; i < 4; i++) begin
            io_upd = 1'b1; run(1, "R11");
            io_upd = 1'b0; run(4, "R11");
        end
        load_rate_upd = 1'b0;
        dir = 1'b0; run(3, "R11");
        dir = 1'b1; run(10, "R11");
        // R5 autoclear on update only
        autoclr = 1'b1; run(5, "R5");
        io_upd = 1'b1; run(1, "R5");
        io_upd = 1'b0; run(10, "R5");
        autoclr = 1'b0;
        // R3 disabled block ignores everything
        en = 1'b0; clr = 1'b1; dir = 1'b0; io_upd = 1'b1; dest = 2'b00;
        run(6, "R3");
        clr = 1'b0; io_upd = 1'b0; autoclr = 1'b1;
        run(4, "R3");
        autoclr = 1'b0; en = 1'b1;
        run(20, "R7");
        // R4 clear held against a running ramp
        dir = 1'b1; clr = 1'b1; run(5, "R4");
        clr = 1'b0; run(10, "R6");
        run(3, "R6");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule